// File: doc/BRIEF.md
# Privileged Status and Cause Register Write Filter

This block holds a processor's privileged Status and Cause control words and applies every software write to them. Each write passes through a writable-bit mask. Further restrictions depend on the architecture release that is enabled. Some bits may be cleared by software but never set. Some fields are held when written with a reserved code. In 64-bit mode, the three address-segment enable bits are chained so that a lower privilege level cannot stay enabled once a higher one is disabled.

Certain bit changes fire one-cycle side-effect strobes. These strobes stop or start the cycle counter, report toggles of the two software interrupt bits, and request a TLB flush when a segment enable is dropped. When multithreading is enabled, each Status write also mirrors the coprocessor-usable, DSP-enable and privilege-mode fields, together with the current address-space identifier, into the status shadow of the selected thread.

Both registers are visible on the outputs in the cycle in which they are held. A write takes effect on the next clock edge. Strobes are registered on that same edge and last exactly one cycle.

Top module: `priv_ctl_regs`

## Requirements
- R1: While reset is asserted and after it, Status reads 0x00400004 (bit 22 boot-vector flag and bit 2 error-level flag set), Cause reads 0, all strobes are low and every thread shadow holds the parameter value SHADOW_INIT.
- R2: A Status write (wr_en=1, wr_sel=0) replaces exactly the bits set in cfg_status_wmask, subject to R3 to R5. All other bits keep their value. The new value appears on status_out after the next rising edge.
- R3: With cfg_rel6=1 and both privilege-mode mask bits [4:3] set, a Status write whose bits [4:3] equal 3 leaves bits [4:3] unchanged.
- R4: With cfg_rel6=1, Status bit 20 (soft-reset flag) and bit 19 (NMI flag) can be cleared by writing 0, but a written 1 is ignored.
- R5: With cfg_rel6=1 and cfg_wide=1, the written value of bit 6 (SX) is forced to 0 when bit 7 (KX) is written 0. Bit 5 (UX) is forced to 0 when the resulting bit 6 is 0.
- R6: With cfg_wide=1, a Status write that changes any of bits [7:5] from 1 to 0 raises tlb_flush_req for one cycle after the write edge.
- R7: A Cause write (wr_en=1, wr_sel=1) changes only bits 23, 22, 9 and 8. It also changes bit 27 (counter-disable, DC) when cfg_rel2=1.
- R8: With cfg_rel6=1, Cause bit 22 (watch-pending) can be cleared but not set by a write.
- R9: A Cause write that sets DC pulses cnt_stop for one cycle. One that clears DC pulses cnt_start for one cycle. The two never pulse together.
- R10: swi_level[1:0] always equals Cause bits [9:8]. swi_toggle[i] pulses for one cycle after a write that toggles Cause bit 8+i.
- R11: With cfg_mt_en=1, a Status write copies the new Status fields into thread thr_sel's shadow: bits [31:28] go to shadow [31:28], bit 24 goes to shadow 27, bits [4:3] go to shadow [12:11], and cur_asid goes to shadow [ASID_W-1:0]. All other shadow bits are kept. shadow_out shows the shadow of thread thr_sel.
- R12: When wr_en=0, neither register, no shadow and no strobe changes, whatever wr_sel and wr_data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Target register: 0 Status, 1 Cause |
| wr_data | input | 32 | Write value |
| cfg_status_wmask | input | 32 | Writable-bit mask for Status |
| cfg_rel2 | input | 1 | Release-2 features enabled |
| cfg_rel6 | input | 1 | Release-6 restrictions enabled |
| cfg_wide | input | 1 | 64-bit addressing mode |
| cfg_mt_en | input | 1 | Multithreading enabled |
| thr_sel | input | THR_W | Thread whose shadow is written and read |
| cur_asid | input | ASID_W | Current address-space identifier |
| status_out | output | 32 | Current Status |
| cause_out | output | 32 | Current Cause |
| shadow_out | output | 32 | Shadow of thread thr_sel |
| cnt_stop | output | 1 | Counter stop pulse |
| cnt_start | output | 1 | Counter start pulse |
| swi_level | output | 2 | Software interrupt line levels |
| swi_toggle | output | 2 | Software interrupt change pulses |
| tlb_flush_req | output | 1 | TLB flush request pulse |

## Verification
The assertions assume that wr_en, wr_sel and the configuration inputs are known values from the first edge after reset. They also assume that thr_sel always names an existing thread, because the thread field is exactly THR_W bits wide.

The stimulus drives every input on the falling edge to a defined value. It holds each configuration for a block of writes and then redraws it from a fixed seed. Half of the drawn masks are fully writable, so that the release-specific filters are actually reached.

// File: rtl/priv_ctl_pkg.sv
// Shared bit positions and reset constants for the privileged register block.
// Assumes 32-bit control words; positions are fixed by the field decoders
// that consume these registers.
package priv_ctl_pkg;
    localparam int XLEN        = 32;
    // Status field positions
    localparam int ST_CU_LSB   = 28;
    localparam int ST_MX       = 24;
    localparam int ST_BEV      = 22;
    localparam int ST_SR       = 20;
    localparam int ST_NMI      = 19;
    localparam int ST_KX       = 7;
    localparam int ST_SX       = 6;
    localparam int ST_UX       = 5;
    localparam int ST_KSU_LSB  = 3;
    localparam int ST_ERL      = 2;
    // Cause field positions
    localparam int CA_DC       = 27;
    localparam int CA_WP       = 22;
    localparam int CA_IP_LSB   = 8;
    localparam logic [XLEN-1:0] CA_BASE_MASK = 32'h00C0_0300;
    // Shadow field positions
    localparam int SH_CU_LSB   = 28;
    localparam int SH_MX       = 27;
    localparam int SH_KSU_LSB  = 11;
    localparam logic [XLEN-1:0] ST_RESET_VAL =
        (XLEN'(1) << ST_BEV) | (XLEN'(1) << ST_ERL);

    typedef struct packed {
        logic       stop;
        logic       start;
        logic [1:0] swi_tgl;
    } cause_evt_t;
endpackage

// File: rtl/status_wr_unit.sv
// Computes the next Status value for a software write and flags a dropped
// segment enable. Purely combinational apart from the guarding assertions.
// Assumes old_q is the registered Status and the caller gates the result
// with its own write enable.
module status_wr_unit
    import priv_ctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] old_q,
    input  logic [XLEN-1:0] wr_val,
    input  logic [XLEN-1:0] wmask,
    input  logic            rel6,
    input  logic            wide,
    output logic [XLEN-1:0] next_val,
    output logic            flush_hit
);
    logic [XLEN-1:0] val_f;
    logic [XLEN-1:0] mask_f;

    // Filter the written value and effective mask per release rules.
    always_comb begin
        val_f  = wr_val;
        mask_f = wmask;
        if (rel6) begin
            if (wide) begin
                val_f[ST_SX] = wr_val[ST_SX] & wr_val[ST_KX];
                val_f[ST_UX] = wr_val[ST_UX] & val_f[ST_SX];
            end
            if ((wmask[ST_KSU_LSB+:2] == 2'b11) && (wr_val[ST_KSU_LSB+:2] == 2'b11))
                mask_f[ST_KSU_LSB+:2] = 2'b00;
            mask_f[ST_SR]  = wmask[ST_SR]  & ~wr_val[ST_SR];
            mask_f[ST_NMI] = wmask[ST_NMI] & ~wr_val[ST_NMI];
        end
    end

    // Merge old and new bits and detect any segment enable falling.
    always_comb begin
        next_val  = (old_q & ~mask_f) | (val_f & mask_f);
        flush_hit = wide && (|(old_q[ST_UX+:3] & ~next_val[ST_UX+:3]));
    end

    p_ksu_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rel6 && wmask[ST_KSU_LSB+:2] == 2'b11 && wr_val[ST_KSU_LSB+:2] == 2'b11)
        |-> next_val[ST_KSU_LSB+:2] == old_q[ST_KSU_LSB+:2]);

    p_sr_noset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rel6 |-> !(next_val[ST_SR] && !old_q[ST_SR]) && !(next_val[ST_NMI] && !old_q[ST_NMI]));

    p_seg_chain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rel6 && wide && wmask[ST_UX+:3] == 3'b111)
        |-> !(next_val[ST_SX] && !next_val[ST_KX]) && !(next_val[ST_UX] && !next_val[ST_SX]));
endmodule

// File: rtl/cause_wr_unit.sv
// Computes the next Cause value for a software write and the events that
// change produces. Assumes old_q is the registered Cause; the caller
// discards the events when no Cause write happens.
module cause_wr_unit
    import priv_ctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] old_q,
    input  logic [XLEN-1:0] wr_val,
    input  logic            rel2,
    input  logic            rel6,
    output logic [XLEN-1:0] next_val,
    output cause_evt_t      evt
);
    logic [XLEN-1:0] mask_f;

    // Build the write mask from release level and clear-only rules.
    always_comb begin
        mask_f = CA_BASE_MASK;
        if (rel2)
            mask_f[CA_DC] = 1'b1;
        if (rel6)
            mask_f[CA_WP] = ~wr_val[CA_WP];
    end

    // Merge and derive counter and interrupt events from bit changes.
    always_comb begin
        next_val      = (old_q & ~mask_f) | (wr_val & mask_f);
        evt.stop      = ~old_q[CA_DC] &  next_val[CA_DC];
        evt.start     =  old_q[CA_DC] & ~next_val[CA_DC];
        evt.swi_tgl   = old_q[CA_IP_LSB+:2] ^ next_val[CA_IP_LSB+:2];
    end

    p_dc_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rel2 |-> next_val[CA_DC] == old_q[CA_DC]);

    p_wp_noset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rel6 |-> !(next_val[CA_WP] && !old_q[CA_WP]));
endmodule

// File: rtl/thread_shadow_bank.sv
// Per-thread status shadows. A mirror write replaces only the mirrored
// fields of the selected thread; other bits keep their contents.
// Assumes ASID_W leaves room below the privilege-mode field (ASID_W <= 11).
module thread_shadow_bank
    import priv_ctl_pkg::*;
#(
    parameter int THR_W  = 2,
    parameter int ASID_W = 8,
    parameter logic [XLEN-1:0] SHADOW_INIT = 32'h0400_A500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mir_we,
    input  logic [THR_W-1:0]  sel,
    input  logic [3:0]        cu,
    input  logic              mx,
    input  logic [1:0]        ksu,
    input  logic [ASID_W-1:0] asid,
    output logic [XLEN-1:0]   rd_data
);
    localparam int THREADS = 1 << THR_W;
    localparam logic [XLEN-1:0] ASID_MASK = (XLEN'(1) << ASID_W) - XLEN'(1);
    localparam logic [XLEN-1:0] MIR_MASK  =
        (XLEN'(4'hF) << SH_CU_LSB) | (XLEN'(1) << SH_MX) |
        (XLEN'(2'b11) << SH_KSU_LSB) | ASID_MASK;

    logic [XLEN-1:0] shd [THREADS];
    logic [XLEN-1:0] mir_val;

    // Place incoming fields at their shadow positions.
    always_comb begin
        mir_val = '0;
        mir_val[SH_CU_LSB+:4]  = cu;
        mir_val[SH_MX]         = mx;
        mir_val[SH_KSU_LSB+:2] = ksu;
        mir_val[ASID_W-1:0]    = asid;
    end

    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        // Hold one thread's shadow, updating mirrored fields on selection.
        always_ff @(posedge clk) begin
            if (!rst_n)
                shd[t] <= SHADOW_INIT;
            else if (mir_we && sel == THR_W'(t))
                shd[t] <= (shd[t] & ~MIR_MASK) | mir_val;
        end

        p_shadow_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !(mir_we && sel == THR_W'(t)) |=> $stable(shd[t]));

        p_shadow_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (shd[t] & ~MIR_MASK) == ($past(shd[t]) & ~MIR_MASK));
    end

    // Read the selected thread's shadow.
    always_comb rd_data = shd[sel];
endmodule

// File: rtl/priv_ctl_regs.sv
// Top of the privileged Status/Cause write block. Holds both registers,
// registers the side-effect strobes on the write edge and drives the
// thread shadow bank. Assumes one write per cycle to at most one register.
module priv_ctl_regs
    import priv_ctl_pkg::*;
#(
    parameter int THR_W  = 2,
    parameter int ASID_W = 8,
    parameter logic [31:0] SHADOW_INIT = 32'h0400_A500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [31:0]       wr_data,
    input  logic [31:0]       cfg_status_wmask,
    input  logic              cfg_rel2,
    input  logic              cfg_rel6,
    input  logic              cfg_wide,
    input  logic              cfg_mt_en,
    input  logic [THR_W-1:0]  thr_sel,
    input  logic [ASID_W-1:0] cur_asid,
    output logic [31:0]       status_out,
    output logic [31:0]       cause_out,
    output logic [31:0]       shadow_out,
    output logic              cnt_stop,
    output logic              cnt_start,
    output logic [1:0]        swi_level,
    output logic [1:0]        swi_toggle,
    output logic              tlb_flush_req
);
    logic [XLEN-1:0] status_q, cause_q;
    logic [XLEN-1:0] st_next, ca_next;
    logic            st_flush;
    cause_evt_t      ca_evt, evt_q;
    logic            flush_q;
    logic            status_we, cause_we;

    // Decode which register the current write targets.
    always_comb begin
        status_we = wr_en && !wr_sel;
        cause_we  = wr_en &&  wr_sel;
    end

    status_wr_unit u_st (
        .clk(clk), .rst_n(rst_n), .old_q(status_q), .wr_val(wr_data),
        .wmask(cfg_status_wmask), .rel6(cfg_rel6), .wide(cfg_wide),
        .next_val(st_next), .flush_hit(st_flush)
    );

    cause_wr_unit u_ca (
        .clk(clk), .rst_n(rst_n), .old_q(cause_q), .wr_val(wr_data),
        .rel2(cfg_rel2), .rel6(cfg_rel6), .next_val(ca_next), .evt(ca_evt)
    );

    thread_shadow_bank #(.THR_W(THR_W), .ASID_W(ASID_W), .SHADOW_INIT(SHADOW_INIT)) u_shd (
        .clk(clk), .rst_n(rst_n), .mir_we(status_we && cfg_mt_en), .sel(thr_sel),
        .cu(st_next[ST_CU_LSB+:4]), .mx(st_next[ST_MX]), .ksu(st_next[ST_KSU_LSB+:2]),
        .asid(cur_asid), .rd_data(shadow_out)
    );

    // Status register update.
    always_ff @(posedge clk) begin
        if (!rst_n)         status_q <= ST_RESET_VAL;
        else if (status_we) status_q <= st_next;
    end

    // Cause register update.
    always_ff @(posedge clk) begin
        if (!rst_n)        cause_q <= '0;
        else if (cause_we) cause_q <= ca_next;
    end

    // One-cycle side-effect strobes registered on the write edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q   <= '0;
            flush_q <= 1'b0;
        end else begin
            evt_q   <= cause_we ? ca_evt : '0;
            flush_q <= status_we && st_flush;
        end
    end

    // Drive outputs from held state.
    always_comb begin
        status_out    = status_q;
        cause_out     = cause_q;
        cnt_stop      = evt_q.stop;
        cnt_start     = evt_q.start;
        swi_level     = cause_q[CA_IP_LSB+:2];
        swi_toggle    = evt_q.swi_tgl;
        tlb_flush_req = flush_q;
    end

    p_status_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !status_we |=> $stable(status_q));

    p_cause_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_we |=> $stable(cause_q));

    p_cnt_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cnt_stop && cnt_start));

    p_stop_dc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_stop |-> cause_q[CA_DC] && !$past(cause_q[CA_DC]));

    p_start_dc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_start |-> !cause_q[CA_DC] && $past(cause_q[CA_DC]));

    p_swi_tgl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        swi_toggle[0] |-> cause_q[CA_IP_LSB] != $past(cause_q[CA_IP_LSB]));

    p_flush_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush_req |-> |($past(status_q[ST_UX+:3]) & ~status_q[ST_UX+:3]));
endmodule

// File: tb/priv_ctl_regs_test.sv
`timescale 1ns/1ps
module priv_ctl_regs_test;
    localparam int THR_W = 2;
    localparam int ASID_W = 8;
    localparam logic [31:0] SH_INIT = 32'h0400_A500;
    localparam logic [31:0] MIR = 32'hF800_1800 | 32'h0000_00FF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_sel = 1'b0;
    logic [31:0] wr_data = '0, cfg_status_wmask = '1;
    logic cfg_rel2 = 1'b1, cfg_rel6 = 1'b1, cfg_wide = 1'b1, cfg_mt_en = 1'b1;
    logic [THR_W-1:0] thr_sel = '0;
    logic [ASID_W-1:0] cur_asid = '0;
    logic [31:0] status_out, cause_out, shadow_out;
    logic cnt_stop, cnt_start, tlb_flush_req;
    logic [1:0] swi_level, swi_toggle;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [31:0] st, ca;
    logic [31:0] msh [4];

    always #10 clk = ~clk;

    priv_ctl_regs #(.THR_W(THR_W), .ASID_W(ASID_W), .SHADOW_INIT(SH_INIT)) uut (.*);

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [31:0] f_status(logic [31:0] o, logic [31:0] v, logic [31:0] m,
                                             bit r6, bit w);
        logic [31:0] vv = v, mm = m;
        if (r6) begin
            if (w) begin
                if (!v[7]) vv[6] = 1'b0;
                if (!vv[6]) vv[5] = 1'b0;
            end
            if (m[4:3] == 2'b11 && v[4:3] == 2'b11) mm[4:3] = 2'b00;
            if (v[20]) mm[20] = 1'b0;
            if (v[19]) mm[19] = 1'b0;
        end
        return (o & ~mm) | (vv & mm);
    endfunction

    function automatic logic [31:0] f_cause(logic [31:0] o, logic [31:0] v, bit r2, bit r6);
        logic [31:0] mm = 32'h00C0_0300;
        if (r2) mm[27] = 1'b1;
        if (r6 && v[22]) mm[22] = 1'b0;
        return (o & ~mm) | (v & mm);
    endfunction

    task automatic step(bit we, bit sel, logic [31:0] d, string ts, string tc);
        logic [31:0] ns, nc, sv;
        logic fl, sp, sa;
        logic [1:0] tg;
        wr_en = we; wr_sel = sel; wr_data = d;
        ns = (we && !sel) ? f_status(st, d, cfg_status_wmask, cfg_rel6, cfg_wide) : st;
        nc = (we && sel) ? f_cause(ca, d, cfg_rel2, cfg_rel6) : ca;
        fl = we && !sel && cfg_wide && (|(st[7:5] & ~ns[7:5]));
        sp = we && sel && !ca[27] && nc[27];
        sa = we && sel && ca[27] && !nc[27];
        tg = (we && sel) ? (ca[9:8] ^ nc[9:8]) : 2'b00;
        if (we && !sel && cfg_mt_en) begin
            sv = '0;
            sv[31:28] = ns[31:28]; sv[27] = ns[24]; sv[12:11] = ns[4:3]; sv[7:0] = cur_asid;
            msh[thr_sel] = (msh[thr_sel] & ~MIR) | sv;
        end
        @(posedge clk);
        @(negedge clk);
        st = ns; ca = nc;
        chk(ts, "status", status_out, st);
        chk(tc, "cause", cause_out, ca);
        chk("R6", "flush", {31'd0, tlb_flush_req}, {31'd0, fl});
        chk("R9", "stop/start", {30'd0, cnt_stop, cnt_start}, {30'd0, sp, sa});
        chk("R10", "swi", {28'd0, swi_level, swi_toggle}, {28'd0, ca[9:8], tg});
        chk("R11", "shadow", shadow_out, msh[thr_sel]);
        wr_en = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd5151));
        for (int i = 0; i < 4; i++) msh[i] = SH_INIT;
        st = 32'h0040_0004; ca = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "status", status_out, 32'h0040_0004);
        chk("R1", "cause", cause_out, 32'h0);
        chk("R1", "strobes", {26'd0, cnt_stop, cnt_start, swi_toggle, tlb_flush_req, 1'b0}, 32'h0);
        chk("R1", "shadow", shadow_out, SH_INIT);
        rst_n = 1'b1;
        step(0, 0, 32'hFFFF_FFFF, "R12", "R12");   // R12: no write
        step(0, 1, 32'hFFFF_FFFF, "R12", "R12");
        step(1, 0, 32'h0018_0000, "R4", "R1");     // R4: SR/NMI cannot be set
        chk("R4", "sr_nmi", {30'd0, status_out[20], status_out[19]}, 32'h0);
        cfg_rel6 = 1'b0;
        step(1, 0, 32'h0018_0000, "R4", "R1");     // set them with rel6 off
        cfg_rel6 = 1'b1;
        step(1, 0, 32'h0000_0000, "R4", "R1");     // R4: clear with 0
        step(1, 0, 32'h0000_0010, "R3", "R1");     // KSU=2
        step(1, 0, 32'h0000_0018, "R3", "R1");     // R3: KSU=3 ignored
        chk("R3", "ksu", {30'd0, status_out[4:3]}, 32'd2);
        step(1, 0, 32'h0000_00E0, "R5", "R1");
        step(1, 0, 32'h0000_0060, "R5", "R1");     // R5/R6: KX=0 clears chain
        chk("R5", "seg", {29'd0, status_out[7:5]}, 32'd0);
        step(1, 1, 32'h0040_0000, "R2", "R8");     // R8: WP cannot be set
        cfg_rel6 = 1'b0;
        step(1, 1, 32'h0040_0000, "R2", "R8");
        cfg_rel6 = 1'b1;
        step(1, 1, 32'h0000_0000, "R2", "R8");     // R8: WP clears
        step(1, 1, 32'h0800_0100, "R2", "R9");     // R9: DC set, IP0 set
        step(1, 1, 32'h0000_0200, "R2", "R9");     // R9: DC clear, both IP toggle
        cfg_rel2 = 1'b0;
        step(1, 1, 32'h0800_0000, "R2", "R7");     // R7: DC locked
        chk("R7", "dc", {31'd0, cause_out[27]}, 32'd0);
        cfg_rel2 = 1'b1;
        thr_sel = 2'd2; cur_asid = 8'h5A;
        step(1, 0, 32'hA100_0008, "R2", "R11");    // R11: mirror into thread 2
        for (int n = 0; n < 1500; n++) begin
            if (n % 40 == 0) begin
                cfg_status_wmask = $urandom_range(0, 1) ? 32'hFFFF_FFFF : $urandom;
                cfg_rel2 = 1'($urandom); cfg_rel6 = 1'($urandom);
                cfg_wide = 1'($urandom); cfg_mt_en = 1'($urandom);
            end
            thr_sel = THR_W'($urandom); cur_asid = ASID_W'($urandom);
            step(1'($urandom_range(0, 3) != 0), 1'($urandom), $urandom, "R2", "R7");
        end
        summary();
    end
endmodule